// File: doc/BRIEF.md
# Flash Execute-Only Access Guard

This block sits in front of on-chip flash and judges every bus transaction on its own, one per cycle. It grants the transaction or answers it with a bus error. The flash is split into equal segments, and the upper address bits select the segment. Each segment carries two separate protection controls. The first, execute-only, lets the processor run code from the segment but keeps other parties from reading it as data. The second, supervisor-only, refuses every access made at user privilege.

The data-read verdict depends on where the processor last fetched instructions. Code that runs from an execute-only segment may read any execute-only segment, including a different one. Code that runs from an unprotected segment may not read them. Right after reset, a window lets supervisor data reads reach execute-only flash, so the reset vector can be read. The first granted instruction fetch closes this window, and it stays closed until the next reset. The debugger is a bus master that never fetches instructions. Every access it makes to an execute-only segment is refused. The protection bits are captured from the init inputs while reset is held.

Top module: `flash_xo_guard`

## Requirements
- R1: A request presented with `req_valid` high gets a response with `rsp_valid` high exactly one clock later. A cycle with `req_valid` low yields `rsp_valid` low one clock later.
- R2: When `rsp_valid` is high, exactly one of `rsp_grant` and `rsp_err` is high. When it is low, both are low.
- R3: A request at user privilege (`req_sup`=0) to a segment whose supervisor-only bit is set is refused with `rsp_err`, for both fetch and data and for both masters.
- R4: Any debugger request (`req_dbg`=1) to a segment whose execute-only bit is set is refused with `rsp_err`, whatever the privilege, the access kind or the last-fetch state. The debugger's `req_fetch` is treated as data.
- R5: A processor instruction fetch (`req_fetch`=1) is granted whenever the supervisor-only check passes, including fetches into execute-only segments.
- R6: A processor data read of an execute-only segment is refused when the last granted fetch was from a segment without the execute-only bit and the reset window is closed.
- R7: A processor data read of an execute-only segment is granted when the last granted fetch was from any execute-only segment (the same one or another), provided R3 passes.
- R8: From reset until the first granted processor fetch, supervisor data reads of execute-only segments are granted. User data reads get no benefit from this window. The first granted fetch closes the window until the next reset.
- R9: Requests to segments with neither protection bit set are granted for both masters and both privileges.
- R10: The segment index is address bits [ADDR_W-1 : ADDR_W-log2(SEG_N)]. Bit n of `xo_init` and `so_init` protects segment n. These inputs are captured only while `rst` is high; changes to them at other times have no effect on verdicts.
- R11: A refused fetch does not close the reset window and does not change the last-fetch state. After reset, the last-fetch state is "unprotected".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads protection bits |
| xo_init | input | SEG_N | Execute-only bit per segment, captured in reset |
| so_init | input | SEG_N | Supervisor-only bit per segment, captured in reset |
| req_valid | input | 1 | A transaction is presented this cycle |
| req_addr | input | ADDR_W | Flash byte address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_sup | input | 1 | 1 = supervisor privilege, 0 = user |
| req_dbg | input | 1 | 1 = debugger master, 0 = processor |
| rsp_valid | output | 1 | Verdict present (one cycle after request) |
| rsp_grant | output | 1 | Access allowed |
| rsp_err | output | 1 | Bus-error strobe |

## Verification
Two effects can meet in a single cycle. A fetch is being granted, and that same grant moves the last-fetch state and closes the reset window. The judgment of the very next data read must therefore see the updated state. The bench issues requests back to back, one per clock, so a fetch is immediately followed by a supervisor read of an execute-only segment. It then checks that the read flips to error after a fetch from unprotected flash, and to grant after a fetch from execute-only flash. A refused fetch placed between window-open reads shows that only granted fetches move this state.

// File: rtl/fxg_pkg.sv
package fxg_pkg;

  typedef enum logic {
    ACC_DATA  = 1'b0,
    ACC_FETCH = 1'b1
  } acc_kind_e;

  typedef struct packed {
    logic grant;      // transaction allowed
    logic fetch_ok;   // granted processor fetch: moves tracker
    logic fetch_xo;   // that fetch landed in execute-only flash
  } verdict_t;

endpackage

// File: rtl/fxg_seg_prot.sv
module fxg_seg_prot #(
  parameter int SEG_N = 32,
  localparam int IDX_W = $clog2(SEG_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEG_N-1:0] xo_init,
  input  logic [SEG_N-1:0] so_init,
  input  logic [IDX_W-1:0] seg_idx,
  output logic             xo_hit,
  output logic             so_hit
);

  logic [SEG_N-1:0] xo_q;
  logic [SEG_N-1:0] so_q;

  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        xo_q[g] <= xo_init[g];
        so_q[g] <= so_init[g];
      end
    end
  end

  always_comb begin
    xo_hit = 1'b0;
    so_hit = 1'b0;
    if (int'(seg_idx) < SEG_N) begin
      xo_hit = xo_q[seg_idx];
      so_hit = so_q[seg_idx];
    end
  end

  // R10
  prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(xo_q) && $stable(so_q)));

endmodule

// File: rtl/fxg_fetch_track.sv
module fxg_fetch_track (
  input  logic clk,
  input  logic rst,
  input  logic fetch_ok,
  input  logic fetch_xo,
  output logic last_xo,
  output logic win_open
);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_xo  <= 1'b0;
      win_open <= 1'b1;
    end else if (fetch_ok) begin
      last_xo  <= fetch_xo;
      win_open <= 1'b0;
    end
  end

  // R8
  win_stays_shut_chk: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> !win_open);

  // R8
  win_close_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_ok |=> !win_open);

  // R11
  track_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_ok |=> ($stable(last_xo) && $stable(win_open)));

endmodule

// File: rtl/fxg_judge.sv
module fxg_judge
  import fxg_pkg::*;
(
  input  logic      valid,
  input  acc_kind_e kind,
  input  logic      sup,
  input  logic      dbg,
  input  logic      xo_hit,
  input  logic      so_hit,
  input  logic      last_xo,
  input  logic      win_open,
  output verdict_t  vd
);

  logic priv_ok;
  logic dbg_ok;
  logic is_fetch;
  logic data_ok;

  always_comb begin
    priv_ok  = !(so_hit && !sup);
    dbg_ok   = !(dbg && xo_hit);
    is_fetch = (kind == ACC_FETCH) && !dbg;
    data_ok  = !xo_hit || last_xo || (win_open && sup);

    vd.grant    = valid && priv_ok && dbg_ok && (is_fetch || data_ok);
    vd.fetch_ok = valid && priv_ok && is_fetch;
    vd.fetch_xo = xo_hit;
  end

endmodule

// File: rtl/flash_xo_guard.sv
module flash_xo_guard
  import fxg_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SEG_N  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEG_N-1:0]  xo_init,
  input  logic [SEG_N-1:0]  so_init,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_fetch,
  input  logic              req_sup,
  input  logic              req_dbg,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_err
);

  localparam int IDX_W = $clog2(SEG_N);

  logic [IDX_W-1:0] seg_idx;
  logic             xo_hit;
  logic             so_hit;
  logic             last_xo;
  logic             win_open;
  verdict_t         vd;
  acc_kind_e        kind;

  assign seg_idx = req_addr[ADDR_W-1 -: IDX_W];
  assign kind    = acc_kind_e'(req_fetch);

  fxg_seg_prot #(.SEG_N(SEG_N)) u_prot (
    .clk     (clk),
    .rst     (rst),
    .xo_init (xo_init),
    .so_init (so_init),
    .seg_idx (seg_idx),
    .xo_hit  (xo_hit),
    .so_hit  (so_hit)
  );

  fxg_fetch_track u_track (
    .clk      (clk),
    .rst      (rst),
    .fetch_ok (vd.fetch_ok),
    .fetch_xo (vd.fetch_xo),
    .last_xo  (last_xo),
    .win_open (win_open)
  );

  fxg_judge u_judge (
    .valid    (req_valid),
    .kind     (kind),
    .sup      (req_sup),
    .dbg      (req_dbg),
    .xo_hit   (xo_hit),
    .so_hit   (so_hit),
    .last_xo  (last_xo),
    .win_open (win_open),
    .vd       (vd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= vd.grant;
      rsp_err   <= req_valid && !vd.grant;
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R1
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R2
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant != rsp_err));

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_grant && !rsp_err));

  // R3
  user_so_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && so_hit && !req_sup) |=> rsp_err);

  // R4
  dbg_xo_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dbg && xo_hit) |=> rsp_err);

  // R5
  fetch_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_fetch && !req_dbg && !(so_hit && !req_sup)) |=> rsp_grant);

endmodule

// File: tb/flash_xo_guard_tb.sv
module flash_xo_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int SEG_N  = 32;
  localparam int SH     = ADDR_W - $clog2(SEG_N);
  localparam int NV     = 18;

  // execute-only: segments 4..7 ; supervisor-only: segments 5 and 10
  localparam logic [SEG_N-1:0] XO_A = 32'h0000_00F0;
  localparam logic [SEG_N-1:0] SO_A = 32'h0000_0420;

  // {fetch, sup, dbg, seg[4:0], expected_grant}
  localparam logic [8:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,5'd4, 1'b1},  // 0  R8 window sup read of XO
    {1'b0,1'b0,1'b0,5'd4, 1'b0},  // 1  R8 user gets no window
    {1'b0,1'b1,1'b0,5'd1, 1'b1},  // 2  R9 plain segment
    {1'b0,1'b1,1'b1,5'd6, 1'b0},  // 3  R4 debugger on XO
    {1'b0,1'b0,1'b1,5'd2, 1'b1},  // 4  R9 debugger plain
    {1'b1,1'b0,1'b0,5'd5, 1'b0},  // 5  R3 user fetch into SO
    {1'b0,1'b1,1'b0,5'd6, 1'b1},  // 6  R11 refused fetch left window open
    {1'b1,1'b1,1'b0,5'd1, 1'b1},  // 7  R5 fetch from plain, closes window
    {1'b0,1'b1,1'b0,5'd4, 1'b0},  // 8  R6 read XO after plain fetch
    {1'b1,1'b0,1'b0,5'd4, 1'b1},  // 9  R5 user fetch into XO
    {1'b0,1'b0,1'b0,5'd7, 1'b1},  // 10 R7 other XO segment readable
    {1'b1,1'b1,1'b1,5'd7, 1'b0},  // 11 R4 debugger even with fetch flag
    {1'b0,1'b0,1'b0,5'd5, 1'b0},  // 12 R3 user read of SO
    {1'b0,1'b1,1'b0,5'd5, 1'b1},  // 13 R7 sup read XO+SO after XO fetch
    {1'b1,1'b1,1'b0,5'd2, 1'b1},  // 14 R5 fetch back to plain
    {1'b0,1'b1,1'b0,5'd6, 1'b0},  // 15 R6 denied again
    {1'b0,1'b0,1'b0,5'd10,1'b0},  // 16 R3 SO-only segment, user
    {1'b0,1'b1,1'b0,5'd10,1'b1}   // 17 R9/R3 SO-only segment, sup
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [SEG_N-1:0]  xo_init;
  logic [SEG_N-1:0]  so_init;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_fetch;
  logic              req_sup;
  logic              req_dbg;
  logic              rsp_valid;
  logic              rsp_grant;
  logic              rsp_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_xo_guard #(.ADDR_W(ADDR_W), .SEG_N(SEG_N)) u_dut (
    .clk(clk), .rst(rst), .xo_init(xo_init), .so_init(so_init),
    .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
    .req_sup(req_sup), .req_dbg(req_dbg),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,grant,err} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic f, input logic s, input logic d,
                       input int seg);
    req_valid = v;
    req_fetch = f;
    req_sup   = s;
    req_dbg   = d;
    req_addr  = ADDR_W'((seg << SH) | 'h1A4);
  endtask

  task automatic do_reset(input logic [SEG_N-1:0] xo, input logic [SEG_N-1:0] so);
    @(negedge clk);
    rst = 1'b1; xo_init = xo; so_init = so;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one request, response sampled at the next falling edge
  task automatic single(input logic f, input logic s, input logic d, input int seg,
                        input logic eg, input string req);
    drive(1'b1, f, s, d, seg);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 0);
    check(req, {rsp_valid, rsp_grant, rsp_err}, {1'b1, eg, !eg});
  endtask

  initial begin
    rst = 1'b1;
    xo_init = XO_A; so_init = SO_A;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 0);
    do_reset(XO_A, SO_A);
    // reset state, R2
    check("R2 reset", {rsp_valid, rsp_grant, rsp_err}, 3'b000);

    // vector walk, back to back; response of i sampled as i+1 is driven (R1, R2)
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][8], VEC[i][7], VEC[i][6], int'(VEC[i][5:1]));
      @(negedge clk);
      check($sformatf("R1/R2 vector %0d", i), {rsp_valid, rsp_grant, rsp_err},
            {1'b1, VEC[i][0], !VEC[i][0]});
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    check("R1 idle", {rsp_valid, rsp_grant, rsp_err}, 3'b000);

    // R10: init changes outside reset ignored
    xo_init = '0; so_init = '0;
    @(negedge clk);
    single(1'b0, 1'b1, 1'b1, 4, 1'b0, "R10 dbg XO kept after init change");
    single(1'b0, 1'b0, 1'b0, 10, 1'b0, "R10 SO kept after init change");

    // R10: new init loaded in reset; top segment uses top index bits
    do_reset(32'h8000_0000, '0);
    single(1'b0, 1'b1, 1'b1, 4, 1'b1, "R10 reload clears seg 4");
    single(1'b0, 1'b1, 1'b1, 31, 1'b0, "R10 seg 31 from top bits");

    // R8/R11: window reopens after reset; fetch into XO then read
    do_reset(XO_A, SO_A);
    single(1'b0, 1'b1, 1'b0, 7, 1'b1, "R8 window reopened");
    single(1'b1, 1'b1, 1'b0, 3, 1'b1, "R5 first fetch");
    single(1'b0, 1'b1, 1'b0, 7, 1'b0, "R8 window closed");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule